// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block gives a processor register access to a configurable number of general-purpose pins. Pins come in groups of eight, and each group is a bank. Each bank has two byte-wide registers. The data register holds the output value for pins that drive. It also returns the live level of pins that receive. The direction register decides, pin by pin, whether the pin drives or receives.

The register port is a simple synchronous interface. Writes take effect on the clock edge when the write enable is high. Reads are combinational from the address. The bank addresses do not start at zero: bank 0 begins one eight-byte stride in. A sixteen-byte reserved window is skipped, so every bank that would fall at or past that window sits sixteen bytes higher. Input levels pass through two flops before software can see them. The pin count is a parameter and must be a whole number of banks. Builds of 136 pins and of 248 pins are both intended.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n belongs to bank n/8 and occupies bit n%8 of that bank's registers; a write to one bank changes no pin of any other bank.
- R2: The linear byte address of a bank register is (bank+1)*8 + t. Here t=0 selects the data register and t=4 selects the direction register, so bank 0 data is 0x08 and bank 0 direction is 0x0C.
- R3: A linear address of 0x90 or more is moved up by 0x10 (bank 17 data is at 0xA0). Byte addresses 0x90 to 0x9F read as zero, and writes to them change nothing.
- R4: A direction bit of 1 makes the pin an input and 0 makes it an output. pin_oe[n] is the inverse of the direction bit, and pin_out[n] equals the output latch bit.
- R5: A data read returns, for input pins, the pin level after two clock edges of synchronization. For output pins it returns the output latch. A direction read returns the direction bits.
- R6: Every write to a data register loads the output latch. This holds when the pin is an input and when the value equals what was just read. The latch shows on pin_out, and it is read back once the pin turns to output.
- R7: The following addresses read as zero and ignore writes: addresses below 0x08, addresses with either of the two low bits set, and addresses past the last configured bank.
- R8: While reset is asserted all pins are inputs (pin_oe all 0), all output latches are 0, and the synchronizer holds 0.
- R9: rdata follows addr combinationally in the same cycle, without waiting for a clock edge.
- R10: NUM_PINS is a multiple of 8. In a 136-pin build, bank 17 (0xA0) does not exist and behaves as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register byte address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Values to drive on the pads |
| pin_oe | output | NUM_PINS | Per-pin output enable, 1 = drive |

## Verification
Register access is tried on these banks:
- banks 0, 5, 16, 17 and 30, in a 248-pin build, which tells the plain formula apart from the shifted addresses above the hole;
- the reserved window itself;
- misaligned, too-low and past-the-end addresses, which should all be inert;
- address 0xA0 in a 136-pin build.

Data reads are tried with these direction patterns:
- all inputs, with input edges timed to separate one synchronizer stage from two;
- a half-input, half-output mix, which shows the per-bit selection between pin level and latch;
- writes to input pins, including a write of the value just read, which distinguishes a real latch update from a read-modify-write shortcut.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NUM_PINS = 136,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int NUM_BANKS = NUM_PINS / 8;
  localparam int SLOT_W    = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] HOLE_LO  = ADDR_W'('h90);
  localparam logic [ADDR_W-1:0] HOLE_SZ  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] HOLE_END = HOLE_LO + HOLE_SZ;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_BANKS);

  logic [ADDR_W-1:0]   lin;
  logic [SLOT_W-1:0]   slot, bank_idx;
  logic                in_hole, hit, sel_dir;
  logic [NUM_PINS-1:0] lat_q, dir_q, sync1_q, sync2_q, view;
  logic [7:0]          rbyte;

  assign in_hole  = (addr >= HOLE_LO) && (addr < HOLE_END);
  assign lin      = (addr >= HOLE_END) ? addr - HOLE_SZ : addr;
  assign slot     = lin[ADDR_W-1:3];
  assign bank_idx = slot - SLOT_W'(1);
  assign sel_dir  = lin[2];
  assign hit      = !in_hole && (lin[1:0] == 2'b00) && (slot != '0) && (slot <= LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic       wsel;
    logic [7:0] lat_b, dir_b;
    assign wsel = wr_en && hit && (bank_idx == SLOT_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_b <= '0;
        dir_b <= '1;
      end else if (wsel) begin
        if (sel_dir) dir_b <= wdata;
        else         lat_b <= wdata;
      end
    end
    assign lat_q[b*8 +: 8] = lat_b;
    assign dir_q[b*8 +: 8] = dir_b;
  end

  assign view = (dir_q & sync2_q) | (~dir_q & lat_q);

  always_comb begin
    rbyte = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_idx == SLOT_W'(b))
        rbyte = sel_dir ? dir_q[b*8 +: 8] : view[b*8 +: 8];
  end

  assign rdata   = hit ? rbyte : 8'h00;
  assign pin_out = lat_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_bank_ctrl_checker.sv
module gpio_bank_ctrl_checker #(
  parameter int NUM_PINS = 136,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic [7:0]          wdata,
  input logic [7:0]          rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  p_reset_state_r8: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0));

  p_hole_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= ADDR_W'('h90) && addr <= ADDR_W'('h9F)) |-> rdata == 8'h00);

  p_bank0_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h08)) |=> pin_out[7:0] == $past(wdata));

  p_bank0_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h0C)) |=> pin_oe[7:0] == ~$past(wdata));

  p_no_write_no_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

  p_output_reads_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'('h08) && pin_oe[0]) |-> rdata[0] == pin_out[0]);

  p_misaligned_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |-> rdata == 8'h00);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  localparam int BIG = 248;
  localparam int SML = 136;
  localparam int AW  = 12;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [AW-1:0]  b_addr = '0, s_addr = '0;
  logic           b_we = 0, s_we = 0;
  logic [7:0]     b_wd = '0, s_wd = '0, b_rd, s_rd;
  logic [BIG-1:0] b_in = '0, b_out, b_oe;
  logic [SML-1:0] s_in = '0, s_out, s_oe;

  gpio_bank_ctrl #(.NUM_PINS(BIG), .ADDR_W(AW)) u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(b_addr), .wr_en(b_we), .wdata(b_wd),
    .rdata(b_rd), .pin_in(b_in), .pin_out(b_out), .pin_oe(b_oe));

  gpio_bank_ctrl #(.NUM_PINS(SML), .ADDR_W(AW)) u_small (
    .clk(clk), .rst_n(rst_n), .addr(s_addr), .wr_en(s_we), .wdata(s_wd),
    .rdata(s_rd), .pin_in(s_in), .pin_out(s_out), .pin_oe(s_oe));

  int checks = 0, failures = 0;
  bit done = 0;

  function automatic int baddr(int b, int t);
    int a = (b + 1) * 8 + t;
    if (a >= 'h90) a += 'h10;
    return a;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit sm, int a, logic [7:0] d);
    @(negedge clk);
    if (sm) begin s_addr = AW'(a); s_wd = d; s_we = 1; end
    else    begin b_addr = AW'(a); b_wd = d; b_we = 1; end
    @(negedge clk);
    s_we = 0; b_we = 0;
  endtask

  task automatic rd_now(bit sm, int a, output logic [7:0] d);
    if (sm) s_addr = AW'(a); else b_addr = AW'(a);
    #1;
    d = sm ? s_rd : b_rd;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R8 oe big", b_oe, 0);
    chk("R8 out big", b_out, 0);
    chk("R8 oe small", s_oe, 0);
    rd_now(0, baddr(3, 4), d);
    chk("R8 dir reads ones", d, 8'hFF);
    rd_now(0, baddr(3, 0), d);
    chk("R8 data reads zero", d, 0);
  endtask

  task automatic t_map;
    int banks[5] = '{0, 5, 16, 17, 30};
    logic [7:0] d;
    foreach (banks[i]) begin
      int b = banks[i];
      logic [7:0] pat = 8'(b * 37 + 5);
      wr(0, baddr(b, 0), pat);
      wr(0, baddr(b, 4), 8'h00);
      chk("R1 R2 pin_out slice", b_out[b*8 +: 8], pat);
      chk("R4 pin_oe slice", b_oe[b*8 +: 8], 8'hFF);
      @(negedge clk);
      rd_now(0, baddr(b, 0), d);
      chk("R5 R9 output reads latch", d, pat);
      rd_now(0, baddr(b, 4), d);
      chk("R5 R9 dir readback", d, 8'h00);
    end
    wr(0, 'hA0, 8'hC3);
    chk("R3 bank17 at 0xA0", b_out[17*8 +: 8], 8'hC3);
    chk("R1 neighbour bank untouched", b_out[1*8 +: 8], 8'h00);
    chk("R1 neighbour bank oe", b_oe[18*8 +: 8], 8'h00);
  endtask

  task automatic t_hole;
    logic [BIG-1:0] so = b_out, se = b_oe;
    logic [7:0] d;
    for (int a = 'h90; a < 'hA0; a += 4) wr(0, a, 8'hFF);
    chk("R3 hole writes ignored out", b_out, so);
    chk("R3 hole writes ignored oe", b_oe, se);
    @(negedge clk);
    rd_now(0, 'h94, d);
    chk("R3 hole reads zero", d, 0);
  endtask

  task automatic t_unmapped;
    int bad[5] = '{'h00, 'h04, 'h09, 'h110, 'h114};
    logic [BIG-1:0] so = b_out, se = b_oe;
    logic [SML-1:0] sso = s_out;
    logic [7:0] d;
    foreach (bad[i]) wr(0, bad[i], 8'hFF);
    chk("R7 unmapped writes ignored out", b_out, so);
    chk("R7 unmapped writes ignored oe", b_oe, se);
    @(negedge clk);
    rd_now(0, 'h0A, d);
    chk("R7 misaligned read zero", d, 0);
    rd_now(0, 'h110, d);
    chk("R7 past end read zero", d, 0);
    wr(1, 'hA0, 8'h77);
    wr(1, 'hA4, 8'h00);
    chk("R10 small bank17 ignored", s_out, sso);
    chk("R10 small oe unchanged", s_oe, 0);
    @(negedge clk);
    rd_now(1, 'hA4, d);
    chk("R10 small bank17 reads zero", d, 0);
    wr(1, 'h88, 8'h3E);
    chk("R10 small bank16 works", s_out[16*8 +: 8], 8'h3E);
  endtask

  task automatic t_input;
    logic [7:0] d;
    @(negedge clk);
    b_in[2*8 +: 8] = 8'h96;
    rd_now(0, baddr(2, 0), d);
    chk("R5 no change before sync", d, 0);
    @(negedge clk);
    rd_now(0, baddr(2, 0), d);
    chk("R5 one stage not visible", d, 0);
    @(negedge clk);
    rd_now(0, baddr(2, 0), d);
    chk("R5 visible after two edges", d, 8'h96);
    wr(0, baddr(4, 4), 8'h0F);
    wr(0, baddr(4, 0), 8'hA5);
    b_in[4*8 +: 8] = 8'h3C;
    repeat (3) @(negedge clk);
    rd_now(0, baddr(4, 0), d);
    chk("R5 mixed direction read", d, 8'hAC);
    chk("R4 mixed oe", b_oe[4*8 +: 8], 8'hF0);
    chk("R4 mixed out", b_out[4*8 +: 8], 8'hA5);
  endtask

  task automatic t_rewrite;
    logic [7:0] d;
    @(negedge clk);
    b_in[6*8 +: 8] = 8'h33;
    repeat (3) @(negedge clk);
    rd_now(0, baddr(6, 0), d);
    chk("R6 read input level", d, 8'h33);
    wr(0, baddr(6, 0), d);
    chk("R6 same-value write loads latch", b_out[6*8 +: 8], 8'h33);
    wr(0, baddr(6, 0), 8'h5A);
    @(negedge clk);
    rd_now(0, baddr(6, 0), d);
    chk("R6 input read ignores latch", d, 8'h33);
    chk("R6 latch on pin_out", b_out[6*8 +: 8], 8'h5A);
    wr(0, baddr(6, 4), 8'h00);
    @(negedge clk);
    rd_now(0, baddr(6, 0), d);
    chk("R6 latch read after turning output", d, 8'h5A);
  endtask

  initial begin
    #500us;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_map();
    t_hole();
    t_unmapped();
    t_input();
    t_rewrite();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule